// File: doc/BRIEF.md
# System Management Message Port Target Responder

This block is the target side of a three-register byte port through which a host processor exchanges request and response messages with a management controller. The host sees a data register at offset 0, a control/status register at offset 1 and a flags register at offset 2. To take one step of a transaction, the host does three things. It loads a data byte, if the step needs one. It writes a control code. It then writes the flags register with bit 0 set. The responder raises busy, holds it for a configurable number of cycles, and then carries out the step. It clears busy when the step is done.

Each step either moves one request byte toward the local side or moves one response byte toward the host. The responder answers each control code with a status code. It also reports two readiness flags: one says it can take another request byte, the other says a response byte is waiting. At the end of a write and at the end of a read, the data register holds the transaction's error code.

On the local side there is a simple message interface. Request bytes come out as single-cycle pulses, and the last byte of a request carries a marker. Response bytes are offered on a level-valid interface together with a completion code, and each response byte is consumed with a take pulse.

Top module: `sysmgmt_port_tgt`

## Requirements
- R1: After reset the data register reads 0x00, the status register reads 0xC0 and the flags register reads 0x00.
- R2: A host write of the flags register with bit 0 set starts a step. Busy (flags bit 0) is then read as 1 for exactly BUSY_CYCLES cycles and is then cleared. A flags write with bit 0 clear has no effect.
- R3: A control code that is legal in the current phase is acknowledged with status = code | 0x80. For example, 0x40 in idle gives 0xC0 and 0x41 gives 0xC1. The exceptions are stated in R8 and R9.
- R4: Write-start (0x41), write-next (0x42) and write-end (0x43) each deliver the host data byte on req_byte, with a one-cycle req_valid pulse at the end of the step. The byte from write-end also carries req_last.
- R5: After write-end, the data register holds 0x00 if all request bytes fit in MAX_REQ. Otherwise it holds 0x05 (buffer full): bytes beyond MAX_REQ are not delivered, no req_last is given, req_abort pulses and the transaction ends.
- R6: Flags bit 6 (request byte can be taken) is 1 exactly when a write is in progress and busy is clear.
- R7: Flags bit 7 (response byte waiting) is 1 only when busy is clear, a write has ended successfully or a read is in progress, and the local side offers a response byte.
- R8: Read-start (0x44) gives status 0xC4. Read-next (0x45) gives 0xC5, or 0xC6 when the byte it presents is the last one. Each of these steps places the next response byte in the data register and pulses rsp_take once.
- R9: Read-end (0x46), issued after the last byte, returns the status to 0xC0 and places rsp_code in the data register.
- R10: A control code that is unknown or out of sequence sets the status to 0xC0 and the data register to 0x02 (illegal control), and ends the transaction. If a transaction was open, req_abort pulses.
- R11: Flags bits 5 to 1 always read 0, so the flags register never reads 0xFF.
- R12: While busy is set, host writes to the data, control and flags registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset: 0 data, 1 control/status, 2 flags |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by host_addr (read has no side effect) |
| req_valid | output | 1 | Request byte pulse |
| req_byte | output | 8 | Request byte |
| req_last | output | 1 | Marks the final request byte |
| req_abort | output | 1 | Pulse: the open transaction was discarded |
| rsp_avail | input | 1 | A response byte is offered |
| rsp_data | input | 8 | Offered response byte |
| rsp_last | input | 1 | Offered byte is the final one |
| rsp_code | input | 8 | Completion code returned at read-end |
| rsp_take | output | 1 | Pulse: offered response byte consumed |

## Verification
The hardest situation to reach is a host write that lands while busy is still set. A well-behaved host always polls busy before writing, so this never happens in normal traffic. The stimulus forces it with a direct write of a conflicting control code in the middle of a step. Buffer-full is similar, because a host that honours the ready flag never causes it. A directed sequence therefore sends MAX_REQ + 2 bytes. Around these directed cases, randomly sized requests and responses with random completion codes are exchanged end to end.

// File: rtl/smp_pkg.sv
package smp_pkg;
   localparam logic [7:0] CC_GETSTAT  = 8'h40;
   localparam logic [7:0] CC_WR_START = 8'h41;
   localparam logic [7:0] CC_WR_NEXT  = 8'h42;
   localparam logic [7:0] CC_WR_END   = 8'h43;
   localparam logic [7:0] CC_RD_START = 8'h44;
   localparam logic [7:0] CC_RD_NEXT  = 8'h45;
   localparam logic [7:0] CC_RD_END   = 8'h46;
   localparam logic [7:0] ST_READY    = 8'hC0;
   localparam logic [7:0] EC_NONE     = 8'h00;
   localparam logic [7:0] EC_BAD_CTL  = 8'h02;
   localparam logic [7:0] EC_FULL     = 8'h05;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WRITE,
      PH_RSPWAIT,
      PH_READ,
      PH_RDLAST
   } phase_t;

   function automatic logic [7:0] ack_of(input logic [7:0] cc);
      return cc | 8'h80;
   endfunction
endpackage

// File: rtl/smp_busy_timer.sv
module smp_busy_timer #(
   parameter int BUSY_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic fire
);
   logic busy_q;

   generate
      if (BUSY_CYCLES == 1) begin : g_single
         assign fire = busy_q;
      end else begin : g_count
         localparam int CW = $clog2(BUSY_CYCLES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (start)
               cnt_q <= CW'(BUSY_CYCLES - 1);
            else if (busy_q && cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign fire = busy_q && (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (start)
         busy_q <= 1'b1;
      else if (fire)
         busy_q <= 1'b0;
   end

   assign busy = busy_q;
endmodule

// File: rtl/smp_host_regs.sv
module smp_host_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] host_addr,
   input  logic       host_wr,
   input  logic [7:0] host_wdata,
   input  logic       busy,
   input  logic       tx_rdy,
   input  logic       rx_rdy,
   input  logic [7:0] status,
   input  logic [7:0] tdata,
   output logic [7:0] ctl,
   output logic [7:0] hdata,
   output logic       start,
   output logic [7:0] flags,
   output logic [7:0] rdata
);
   logic wr_ok;
   assign wr_ok = host_wr && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl   <= smp_pkg::CC_GETSTAT;
         hdata <= 8'h00;
      end else if (wr_ok) begin
         if (host_addr == 2'd0) hdata <= host_wdata;
         if (host_addr == 2'd1) ctl   <= host_wdata;
      end
   end

   assign start = wr_ok && (host_addr == 2'd2) && host_wdata[0];
   assign flags = {rx_rdy, tx_rdy, 5'b00000, busy};

   always_comb begin
      case (host_addr)
         2'd0:    rdata = tdata;
         2'd1:    rdata = status;
         2'd2:    rdata = flags;
         default: rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/smp_step_engine.sv
module smp_step_engine
   import smp_pkg::*;
#(
   parameter int MAX_REQ = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [7:0]   ctl,
   input  logic [7:0]   hdata,
   input  logic         rsp_avail,
   input  logic [7:0]   rsp_data,
   input  logic         rsp_last,
   input  logic [7:0]   rsp_code,
   output logic [7:0]   status,
   output logic [7:0]   tdata,
   output phase_t       phase,
   output logic         req_valid,
   output logic [7:0]   req_byte,
   output logic         req_last,
   output logic         req_abort,
   output logic         rsp_take
);
   localparam int CNTW = $clog2(MAX_REQ + 1);

   logic [7:0]    status_d, tdata_d, rb_d;
   phase_t        phase_d;
   logic [CNTW-1:0] cnt_q, cnt_d;
   logic          ovf_q, ovf_d;
   logic          rv_d, rl_d, ra_d, take_d, legal, room;

   assign room = (cnt_q < CNTW'(MAX_REQ));

   always_comb begin
      status_d = status;
      tdata_d  = tdata;
      phase_d  = phase;
      cnt_d    = cnt_q;
      ovf_d    = ovf_q;
      rb_d     = req_byte;
      rv_d     = 1'b0;
      rl_d     = 1'b0;
      ra_d     = 1'b0;
      take_d   = 1'b0;
      legal    = 1'b0;
      if (fire) begin
         case (ctl)
            CC_GETSTAT: if (phase == PH_IDLE) begin
               legal    = 1'b1;
               status_d = ST_READY;
            end
            CC_WR_START: if (phase == PH_IDLE) begin
               legal    = 1'b1;
               status_d = ack_of(ctl);
               rv_d     = 1'b1;
               rb_d     = hdata;
               cnt_d    = CNTW'(1);
               ovf_d    = 1'b0;
               phase_d  = PH_WRITE;
            end
            CC_WR_NEXT: if (phase == PH_WRITE) begin
               legal    = 1'b1;
               status_d = ack_of(ctl);
               if (room) begin
                  rv_d  = 1'b1;
                  rb_d  = hdata;
                  cnt_d = cnt_q + CNTW'(1);
               end else begin
                  ovf_d = 1'b1;
               end
            end
            CC_WR_END: if (phase == PH_WRITE) begin
               legal    = 1'b1;
               status_d = ack_of(ctl);
               if (room && !ovf_q) begin
                  rv_d    = 1'b1;
                  rl_d    = 1'b1;
                  rb_d    = hdata;
                  tdata_d = EC_NONE;
                  phase_d = PH_RSPWAIT;
               end else begin
                  tdata_d = EC_FULL;
                  ra_d    = 1'b1;
                  phase_d = PH_IDLE;
               end
            end
            CC_RD_START: if (phase == PH_RSPWAIT && rsp_avail) begin
               legal    = 1'b1;
               status_d = ack_of(ctl);
               tdata_d  = rsp_data;
               take_d   = 1'b1;
               phase_d  = rsp_last ? PH_RDLAST : PH_READ;
            end
            CC_RD_NEXT: if (phase == PH_READ && rsp_avail) begin
               legal    = 1'b1;
               status_d = rsp_last ? ack_of(CC_RD_END) : ack_of(ctl);
               tdata_d  = rsp_data;
               take_d   = 1'b1;
               phase_d  = rsp_last ? PH_RDLAST : PH_READ;
            end
            CC_RD_END: if (phase == PH_RDLAST) begin
               legal    = 1'b1;
               status_d = ST_READY;
               tdata_d  = rsp_code;
               phase_d  = PH_IDLE;
            end
            default: legal = 1'b0;
         endcase
         if (!legal) begin
            status_d = ST_READY;
            tdata_d  = EC_BAD_CTL;
            phase_d  = PH_IDLE;
            ra_d     = (phase != PH_IDLE);
            rv_d     = 1'b0;
            rl_d     = 1'b0;
            take_d   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status    <= ST_READY;
         tdata     <= 8'h00;
         phase     <= PH_IDLE;
         cnt_q     <= '0;
         ovf_q     <= 1'b0;
         req_valid <= 1'b0;
         req_byte  <= 8'h00;
         req_last  <= 1'b0;
         req_abort <= 1'b0;
         rsp_take  <= 1'b0;
      end else begin
         status    <= status_d;
         tdata     <= tdata_d;
         phase     <= phase_d;
         cnt_q     <= cnt_d;
         ovf_q     <= ovf_d;
         req_valid <= rv_d;
         req_byte  <= rb_d;
         req_last  <= rl_d;
         req_abort <= ra_d;
         rsp_take  <= take_d;
      end
   end
endmodule

// File: rtl/sysmgmt_port_tgt.sv
module sysmgmt_port_tgt
   import smp_pkg::*;
#(
   parameter int BUSY_CYCLES = 3,
   parameter int MAX_REQ     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] host_addr,
   input  logic       host_wr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       req_valid,
   output logic [7:0] req_byte,
   output logic       req_last,
   output logic       req_abort,
   input  logic       rsp_avail,
   input  logic [7:0] rsp_data,
   input  logic       rsp_last,
   input  logic [7:0] rsp_code,
   output logic       rsp_take
);
   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (MAX_REQ < 2) begin : g_bad_req
         $error("MAX_REQ must be at least 2");
      end
   endgenerate

   logic       busy_w, fire_w, start_w, tx_rdy_w, rx_rdy_w;
   logic [7:0] ctl_w, hdata_w, status_w, tdata_w, flags_w;
   phase_t     phase_w;

   assign tx_rdy_w = !busy_w && (phase_w == PH_WRITE);
   assign rx_rdy_w = !busy_w && rsp_avail &&
                     (phase_w == PH_RSPWAIT || phase_w == PH_READ);

   smp_host_regs u_regs (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .busy(busy_w), .tx_rdy(tx_rdy_w), .rx_rdy(rx_rdy_w),
      .status(status_w), .tdata(tdata_w), .ctl(ctl_w), .hdata(hdata_w),
      .start(start_w), .flags(flags_w), .rdata(host_rdata)
   );

   smp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_w), .busy(busy_w), .fire(fire_w)
   );

   smp_step_engine #(.MAX_REQ(MAX_REQ)) u_engine (
      .clk(clk), .rst_n(rst_n), .fire(fire_w), .ctl(ctl_w), .hdata(hdata_w),
      .rsp_avail(rsp_avail), .rsp_data(rsp_data), .rsp_last(rsp_last),
      .rsp_code(rsp_code), .status(status_w), .tdata(tdata_w), .phase(phase_w),
      .req_valid(req_valid), .req_byte(req_byte), .req_last(req_last),
      .req_abort(req_abort), .rsp_take(rsp_take)
   );
endmodule

// File: rtl/sysmgmt_port_tgt_chk.sv
module sysmgmt_port_tgt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic [7:0] flags,
   input logic [7:0] status,
   input logic       req_valid,
   input logic       req_last,
   input logic       rsp_take
);
   a_r11_flags_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      flags[5:1] == 5'b00000);
   a_r6_tx_rdy_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      flags[6] |-> !flags[0]);
   a_r7_rx_rdy_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      flags[7] |-> !flags[0]);
   a_r4_req_at_step_end: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($past(busy) && !busy));
   a_r8_take_at_step_end: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_take |-> ($past(busy) && !busy));
   a_r12_status_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(status));
   a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_last |-> req_valid);
endmodule

bind sysmgmt_port_tgt sysmgmt_port_tgt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .flags(flags_w), .status(status_w),
   .req_valid(req_valid), .req_last(req_last), .rsp_take(rsp_take)
);

// File: tb/sysmgmt_port_tgt_tb_top.sv
`timescale 1ns/1ps
module sysmgmt_port_tgt_tb_top;
   localparam int BUSY_CYCLES = 3;
   localparam int MAX_REQ     = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, host_wr, req_valid, req_last, req_abort, rsp_take;
   logic       rsp_avail, rsp_last;
   logic [1:0] host_addr;
   logic [7:0] host_wdata, host_rdata, req_byte, rsp_data, rsp_code;

   int n_run = 0, n_fail = 0;
   logic [7:0] cap_b [0:1023];
   bit         cap_l [0:1023];
   int ncap = 0, nabort = 0, ridx = 0;
   logic [7:0] rmem [0:15];
   int  rbase = 0, rlen = 0;
   bit  ren = 1'b0;
   logic [7:0] wmem [0:15];

   assign rsp_avail = ren && ((ridx - rbase) < rlen);
   assign rsp_data  = rmem[(ridx - rbase) & 15];
   assign rsp_last  = ((ridx - rbase) == rlen - 1);

   sysmgmt_port_tgt #(.BUSY_CYCLES(BUSY_CYCLES), .MAX_REQ(MAX_REQ)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
      .req_byte(req_byte), .req_last(req_last), .req_abort(req_abort),
      .rsp_avail(rsp_avail), .rsp_data(rsp_data), .rsp_last(rsp_last),
      .rsp_code(rsp_code), .rsp_take(rsp_take)
   );

   always @(negedge clk) begin
      if (req_valid) begin
         cap_b[ncap & 1023] = req_byte;
         cap_l[ncap & 1023] = req_last;
         ncap++;
      end
      if (req_abort) nabort++;
      if (rsp_take) ridx++;
   end

   function automatic logic [7:0] exp_ack(input logic [7:0] cc);
      return cc | 8'h80;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic hwr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [1:0] a, output logic [7:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
   endtask

   task automatic wait_done;
      logic [7:0] f;
      for (int i = 0; i < 100; i++) begin
         hrd(2'd2, f);
         if (!f[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic step(input logic [7:0] cc, input logic [7:0] d);
      hwr(2'd0, d);
      hwr(2'd1, cc);
      hwr(2'd2, 8'h01);
      wait_done;
   endtask

   task automatic do_txn(input int nw, input int nr, input logic [7:0] code);
      logic [7:0] v;
      int base;
      for (int i = 0; i < nw; i++) wmem[i] = 8'($urandom);
      for (int i = 0; i < nr; i++) rmem[i] = 8'($urandom);
      ren = 1'b0; rbase = ridx; rlen = nr; rsp_code = code;
      base = ncap;
      step(8'h40, 8'h00);
      hrd(2'd1, v); chk("R3 get-status ack", v, 8'hC0);
      step(8'h41, wmem[0]);
      hrd(2'd1, v); chk("R3 write-start ack", v, exp_ack(8'h41));
      for (int i = 1; i < nw - 1; i++) begin
         hrd(2'd2, v); chk("R6 tx ready in write", v[6], 1);
         step(8'h42, wmem[i]);
         hrd(2'd1, v); chk("R3 write-next ack", v, exp_ack(8'h42));
      end
      step(8'h43, wmem[nw-1]);
      hrd(2'd1, v); chk("R3 write-end ack", v, exp_ack(8'h43));
      hrd(2'd0, v); chk("R5 write code success", v, 8'h00);
      chk("R4 request byte count", ncap - base, nw);
      for (int i = 0; i < nw; i++) begin
         chk("R4 request byte", cap_b[(base + i) & 1023], wmem[i]);
         chk("R4 request last marker", cap_l[(base + i) & 1023], (i == nw - 1) ? 1 : 0);
      end
      hrd(2'd2, v); chk("R7 rx ready low without response", v[7], 0);
      ren = 1'b1;
      hrd(2'd2, v); chk("R7 rx ready with response", v[7], 1);
      step(8'h44, 8'h00);
      hrd(2'd1, v); chk("R8 read-start status", v, 8'hC4);
      hrd(2'd0, v); chk("R8 first response byte", v, rmem[0]);
      for (int j = 1; j < nr; j++) begin
         step(8'h45, 8'h00);
         hrd(2'd1, v); chk("R8 read-next status", v, (j == nr - 1) ? 8'hC6 : 8'hC5);
         hrd(2'd0, v); chk("R8 response byte", v, rmem[j]);
      end
      chk("R8 bytes taken", ridx - rbase, nr);
      step(8'h46, 8'h00);
      hrd(2'd1, v); chk("R9 read-end status", v, 8'hC0);
      hrd(2'd0, v); chk("R9 completion code", v, code);
      ren = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      summary;
   end

   initial begin
      logic [7:0] v;
      int n, base, ab;
      void'($urandom(32'd4711));
      rst_n = 1'b0; host_wr = 1'b0; host_addr = 2'd0; host_wdata = 8'h00; rsp_code = 8'h00;
      repeat (3) @(negedge clk);
      hrd(2'd0, v); chk("R1 reset data", v, 8'h00);
      hrd(2'd1, v); chk("R1 reset status", v, 8'hC0);
      hrd(2'd2, v); chk("R1 reset flags", v, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: busy length
      base = ncap;
      hwr(2'd0, 8'h11); hwr(2'd1, 8'h41); hwr(2'd2, 8'h01);
      n = 0;
      for (int i = 0; i < 50; i++) begin
         hrd(2'd2, v);
         if (!v[0]) break;
         n++;
         @(negedge clk);
      end
      chk("R2 busy cycles", n, BUSY_CYCLES);
      hrd(2'd1, v); chk("R3 write-start ack", v, 8'hC1);
      chk("R4 first request byte", cap_b[base & 1023], 8'h11);
      hrd(2'd2, v); chk("R6 tx ready flags", v, 8'h40);

      // R10: out-of-sequence mid-write
      ab = nabort;
      step(8'h44, 8'h00);
      hrd(2'd1, v); chk("R10 status after illegal", v, 8'hC0);
      hrd(2'd0, v); chk("R10 illegal control code", v, 8'h02);
      chk("R10 abort pulse", nabort - ab, 1);
      hrd(2'd2, v); chk("R6 tx ready cleared", v[6], 0);

      // R2: flags write with bit 0 clear
      hwr(2'd2, 8'hFE);
      hrd(2'd2, v); chk("R2 no step on bit0 clear", v, 8'h00);
      chk("R11 reserved flag bits", v[5:1], 0);

      // R12: writes during busy ignored
      base = ncap;
      hwr(2'd0, 8'h22); hwr(2'd1, 8'h41); hwr(2'd2, 8'h01);
      hwr(2'd1, 8'h45);
      wait_done;
      hrd(2'd1, v); chk("R12 control write ignored while busy", v, 8'hC1);
      chk("R12 byte from before busy", cap_b[base & 1023], 8'h22);
      ab = nabort;
      step(8'h40, 8'h00);
      chk("R10 get-status in write aborts", nabort - ab, 1);

      // R10: illegal in idle, unknown code
      ab = nabort;
      step(8'h45, 8'h00);
      hrd(2'd0, v); chk("R10 idle illegal code", v, 8'h02);
      step(8'h40, 8'h00);
      step(8'h7F, 8'h00);
      hrd(2'd0, v); chk("R10 unknown code", v, 8'h02);
      hrd(2'd1, v); chk("R10 unknown code status", v, 8'hC0);
      chk("R10 no abort in idle", nabort - ab, 0);

      // R5: buffer full
      base = ncap; ab = nabort;
      step(8'h41, 8'hA0);
      for (int i = 1; i <= MAX_REQ; i++) step(8'h42, 8'(8'hA0 + i));
      step(8'h43, 8'hFF);
      hrd(2'd1, v); chk("R5 write-end ack on overflow", v, 8'hC3);
      hrd(2'd0, v); chk("R5 buffer full code", v, 8'h05);
      chk("R5 bytes delivered", ncap - base, MAX_REQ);
      chk("R5 abort pulse", nabort - ab, 1);
      chk("R5 no last marker", cap_l[(ncap - 1) & 1023], 0);
      ren = 1'b1; rbase = ridx; rlen = 2;
      hrd(2'd2, v); chk("R7 no rx ready after overflow", v[7], 0);
      ren = 1'b0;

      // random transactions, including the size bounds
      do_txn(2, 2, 8'h00);
      do_txn(MAX_REQ, 2, 8'h05);
      for (int t = 0; t < 20; t++)
         do_txn(2 + int'($urandom_range(MAX_REQ - 2)), 2 + int'($urandom_range(6)),
                8'($urandom_range(5)));

      summary;
   end
endmodule